// File: doc/BRIEF.md
# High Memory Alias Decoder

This block classifies a 32-bit CPU address that lands in the last megabyte below 16 MB (0x00F00000 to 0x00FFFFFF) or in the top megabyte of the 4 GB space (0xFFF00000 to 0xFFFFFFFF). For each address it picks a target: plain RAM, one of the video memory windows, or "same as the low 1 MB map". It also gives the address that the chosen target should see. The decode is purely combinational in the address. The result depends on one stored flag, the video alias enable.

A single 8-bit control register sets the flag. Writing a byte with bit 2 set gives the 16 MB megabyte back to RAM. Writing a byte with bit 2 clear turns the video aliasing on. A read returns the state of the flag. The upper-memory part of the top-of-4GB megabyte (offsets 0xA0000 and up) always follows the low map, whatever the flag says.

A `low` target means the access should be routed like the low-memory address on `map_addr`. That low-memory decode and the video arrays live outside this block.

Top module: `hi_mem_alias_decoder`

## Requirements
- R1: After reset the video alias is on, and `ctl_rdata` reads 0x00.
- R2: A write (`ctl_wr` high at a clock edge) with `ctl_wdata[2]`=1 turns the alias off, and `ctl_rdata` then reads 0x04. A write with `ctl_wdata[2]`=0 turns it on, and `ctl_rdata` then reads 0x00. All other data bits have no effect.
- R3: With the alias off, any address 0x00F00000–0x00FFFFFF gives target code 1 (RAM), with `map_addr` = address bits 19:0.
- R4: With the alias on, 0x00F00000–0x00F9FFFF gives code 2 (extended graphics, 640 KB), with `map_addr` = address bits 19:0.
- R5: With the alias on, four ranges give a video code, each with `map_addr` = offset inside its window. 0x00FA0000–0x00FA7FFF gives code 3 (text), offset = bits 14:0. 0x00FA8000–0x00FAFFFF gives code 4 (first graphics plane), offset = bits 14:0. 0x00FB0000–0x00FBFFFF gives code 5 (graphics planes, 64 KB), offset = bits 15:0. 0x00FE0000–0x00FE7FFF gives code 6 (E-plane), offset = bits 14:0.
- R6: With the alias on, 0x00FC0000–0x00FDFFFF and 0x00FE8000–0x00FFFFFF give code 7 (follow the low map), with `map_addr` = address bits 19:0.
- R7: 0xFFFA0000–0xFFFFFFFF gives code 7 with `map_addr` = bits 19:0, regardless of the flag. 0xFFF00000–0xFFF9FFFF gives code 0.
- R8: Any address outside the two megabytes gives code 0 (no alias), with `map_addr` = bits 19:0.
- R9: An access in the same cycle as a control write is decoded with the old flag. The new setting applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; bit 2 = alias off |
| ctl_rdata | output | 8 | Control read data: 0x04 alias off, 0x00 alias on |
| cpu_addr | input | 32 | CPU address to classify |
| tgt_code | output | 3 | 0 none, 1 RAM, 2 ext gfx, 3 text, 4 plane A, 5 planes B, 6 E-plane, 7 low map |
| map_addr | output | 20 | Address presented to the selected target |

## Verification
The only internal state is the alias flag. If that flag is wrong, the error shows in the cycle right after the faulty write, both on `ctl_rdata` and on the code of every 0x00Fxxxxx address. The sweeps therefore re-read the register and walk the whole megabyte after each write. Decode faults show at once for the addresses they affect. Page-granular sweeps with an in-page offset cover every window edge in both flag states.

// File: rtl/hi_mem_alias_decoder.sv
module hi_mem_alias_decoder #(
  parameter int AW = 32,
  parameter int OW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic [AW-1:0] cpu_addr,
  output logic [2:0]    tgt_code,
  output logic [OW-1:0] map_addr
);
  localparam logic [2:0] T_NONE = 3'd0, T_RAM = 3'd1, T_XGFX = 3'd2, T_TEXT = 3'd3,
                         T_PLA = 3'd4, T_PLB = 3'd5, T_PLE = 3'd6, T_LOW = 3'd7;
  localparam int HW = AW - OW;
  localparam logic [HW-1:0] SEG_16M = HW'(12'h00F);
  localparam logic [HW-1:0] SEG_TOP = {HW{1'b1}};

  logic alias_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      alias_on <= 1'b1;
    else if (ctl_wr) alias_on <= ~ctl_wdata[2];

  assign ctl_rdata = {5'b0, ~alias_on, 2'b0};

  logic [HW-1:0] seg;
  logic [OW-1:0] off;
  assign seg = cpu_addr[AW-1:OW];
  assign off = cpu_addr[OW-1:0];

  always_comb begin
    tgt_code = T_NONE;
    map_addr = off;
    if (seg == SEG_TOP) begin
      if (off >= OW'(20'hA0000)) tgt_code = T_LOW;
    end else if (seg == SEG_16M) begin
      if (!alias_on)                     tgt_code = T_RAM;
      else if (off < OW'(20'hA0000))     tgt_code = T_XGFX;
      else if (off < OW'(20'hA8000)) begin tgt_code = T_TEXT; map_addr = OW'(off[14:0]); end
      else if (off < OW'(20'hB0000)) begin tgt_code = T_PLA;  map_addr = OW'(off[14:0]); end
      else if (off < OW'(20'hC0000)) begin tgt_code = T_PLB;  map_addr = OW'(off[15:0]); end
      else if (off < OW'(20'hE0000))     tgt_code = T_LOW;
      else if (off < OW'(20'hE8000)) begin tgt_code = T_PLE;  map_addr = OW'(off[14:0]); end
      else                               tgt_code = T_LOW;
    end
  end
endmodule

// File: rtl/hi_mem_alias_decoder_chk.sv
module hi_mem_alias_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic [7:0]  ctl_wdata,
  input logic [7:0]  ctl_rdata,
  input logic [31:0] cpu_addr,
  input logic [2:0]  tgt_code,
  input logic [19:0] map_addr
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ctl_rdata == 8'h00);
  // R2
  write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[2]) |=> ctl_rdata == 8'h04);
  // R2
  write_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[2]) |=> ctl_rdata == 8'h00);
  // R9
  hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl_rdata));
  // R3
  ram_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata == 8'h04 && cpu_addr[31:20] == 12'h00F) |-> (tgt_code == 3'd1 && map_addr == cpu_addr[19:0]));
  // R7
  top_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[31:20] == 12'hFFF && cpu_addr[19:0] >= 20'hA0000) |-> (tgt_code == 3'd7 && map_addr == cpu_addr[19:0]));
  // R8
  no_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[31:20] != 12'hFFF && cpu_addr[31:20] != 12'h00F) |-> (tgt_code == 3'd0 && map_addr == cpu_addr[19:0]));
endmodule

bind hi_mem_alias_decoder hi_mem_alias_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .cpu_addr(cpu_addr), .tgt_code(tgt_code), .map_addr(map_addr)
);

// File: tb/hi_mem_alias_decoder_test.sv
module hi_mem_alias_decoder_test;
  logic clk = 0, rst_n = 0, ctl_wr = 0;
  logic [7:0] ctl_wdata = 0, ctl_rdata;
  logic [31:0] cpu_addr = 0;
  logic [2:0] tgt_code;
  logic [19:0] map_addr;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hi_mem_alias_decoder uut (.clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cpu_addr(cpu_addr), .tgt_code(tgt_code), .map_addr(map_addr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, cpu_addr, act, exp);
    end
  endtask

  function automatic logic [22:0] expect_of(logic [31:0] a, bit on);
    logic [19:0] o = a[19:0];
    if (a[31:20] == 12'hFFF) return {(o >= 20'hA0000) ? 3'd7 : 3'd0, o};
    if (a[31:20] != 12'h00F) return {3'd0, o};
    if (!on) return {3'd1, o};
    if (o < 20'hA0000) return {3'd2, o};
    if (o < 20'hA8000) return {3'd3, o - 20'hA0000};
    if (o < 20'hB0000) return {3'd4, o - 20'hA8000};
    if (o < 20'hC0000) return {3'd5, o - 20'hB0000};
    if (o < 20'hE0000) return {3'd7, o};
    if (o < 20'hE8000) return {3'd6, o - 20'hE0000};
    return {3'd7, o};
  endfunction

  function automatic string req_of(logic [31:0] a, bit on);
    logic [19:0] o = a[19:0];
    if (a[31:20] == 12'hFFF) return "R7";
    if (a[31:20] != 12'h00F) return "R8";
    if (!on) return "R3";
    if (o < 20'hA0000) return "R4";
    if ((o >= 20'hC0000 && o < 20'hE0000) || o >= 20'hE8000) return "R6";
    return "R5";
  endfunction

  task automatic probe(logic [31:0] a, bit on);
    logic [22:0] e = expect_of(a, on);
    cpu_addr = a;
    #2;
    chk(req_of(a, on), {29'd0, tgt_code}, {29'd0, e[22:20]});
    chk(req_of(a, on), {12'd0, map_addr}, {12'd0, e[19:0]});
  endtask

  task automatic ctl_write(logic [7:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic sweep(bit on);
    for (int p = 0; p < 256; p++) begin
      probe(32'h00F00000 + p * 32'h1000 + ((p * 37) & 32'hFFF), on);
      probe(32'h00F00000 + p * 32'h1000 + 32'hFFF, on);
      probe(32'hFFF00000 + p * 32'h1000 + ((p * 53) & 32'hFFF), on);
    end
    probe(32'h00E00000 + 32'hFFFFF, on);
    probe(32'h01000000, on);
    probe(32'h000A0000, on);
    probe(32'hFFE00000 + 32'hA0000, on);
    probe(32'h80F00000, on);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {24'd0, ctl_rdata}, 32'h00);
    sweep(1);
    ctl_write(8'h04);
    chk("R2", {24'd0, ctl_rdata}, 32'h04);
    sweep(0);
    ctl_write(8'hFB);
    chk("R2", {24'd0, ctl_rdata}, 32'h00);
    sweep(1);
    ctl_write(8'hFF);
    chk("R2", {24'd0, ctl_rdata}, 32'h04);
    ctl_write(8'h04);
    chk("R2", {24'd0, ctl_rdata}, 32'h04);
    ctl_write(8'h00);
    chk("R2", {24'd0, ctl_rdata}, 32'h00);
    // R9: an access in the write cycle sees the old flag
    @(negedge clk); ctl_wr = 1; ctl_wdata = 8'h04; cpu_addr = 32'h00FA0010;
    #2 chk("R9", {29'd0, tgt_code}, 32'd3);
    @(negedge clk); ctl_wr = 0;
    #2 chk("R9", {29'd0, tgt_code}, 32'd1);
    @(negedge clk); ctl_wr = 1; ctl_wdata = 8'h00; cpu_addr = 32'h00FE0020;
    #2 chk("R9", {29'd0, tgt_code}, 32'd1);
    @(negedge clk); ctl_wr = 0;
    #2 chk("R9", {29'd0, tgt_code}, 32'd6);
    chk("R9", {12'd0, map_addr}, 32'h20);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule